// File: doc/BRIEF.md
# Macroblock Object Packer

The packer drains the words of coded macroblocks from a scalar first-word-fall-through FIFO and rebuilds each macroblock as one addressed object in an object FIFO. Each word is written to a fixed slot of the object, and the object is closed with a commit once its last word has been written. A macroblock is made of up to ten word groups that always arrive in the same order. Only the header group is always there. Header word 0 carries a set of flags and the 6-bit coded block pattern (CBP). These fields decide which of the other groups follow. The block tracks this syntax, so the consumer sees one complete object per macroblock, with no scheduling left to the producer.

Flow control is local to the block. A word is popped only when the input FIFO shows data and the object FIFO can accept a write. While the object FIFO is full, nothing moves and no data is lost. After each commit a one-cycle done pulse appears, together with the number of words written for that macroblock.

Header word 0 layout with default parameters:

| Bits | Meaning |
|------|---------|
| 0 | inter-predicted |
| 1 | intra 16x16 |
| 2 | macroblock type is zero |
| 3 | bidirectional slice |
| 4 | 8x8 transform |
| 13:8 | CBP |

Object FIFO op codes: NOP = 0, WRITE = 1, COMMIT = 2.

Top module: `mb_obj_packer`

## Requirements
- R1: Every macroblock starts with 5 header words written to addresses 0 to 4. For an intra macroblock (bit 0 of header word 0 clear), 8 prediction-mode words follow at addresses 5 to 12.
- R2: Within one macroblock, words are written in arrival order and each write address is higher than the previous one. Each input word appears unchanged on the object data port.
- R3: For an inter macroblock (bit 0 set), no prediction-mode words are expected. Instead, 9 reference-list words go to addresses 13 to 21, then 32 motion-vector-difference words go to addresses 22 to 53.
- R4: Residual groups (luma and chroma) are expected when either condition holds:
  - the type-is-zero flag (bit 2) is clear, or
  - the bidirectional flag (bit 3) is set and the CBP (bits 13:8) is nonzero.
  Otherwise the commit follows the last prediction word, whatever the CBP says.
- R5: `in_re` is asserted only in cycles where `in_empty` is low. While the input is empty, the block waits.
- R6: While `obj_full` is high, the op is NOP and `in_re` is low. Transfer resumes afterwards without dropping or repeating a word.
- R7: A residual macroblock that is not intra 16x16 (bit 1 clear) and has a nonzero CBP carries 128 luma words. They are written at 54 to 181 when bit 4 is clear, or at 182 to 309 when bit 4 is set.
- R8: A residual intra 16x16 macroblock carries 16 luma DC words at 310 to 325. If the CBP's low four bits are nonzero, 112 luma AC words follow at 326 to 437.
- R9: In a residual macroblock, 8 chroma DC words go to 438 to 445 when the CBP exceeds 15. 58 chroma AC words go to 446 to 503 when the CBP's upper two bits equal 2.
- R10: The cycle after the last expected write, the block issues exactly one COMMIT (op 2). The cycle after the commit, `mb_done` pulses with `mb_words` equal to the number of writes in that macroblock. The next macroblock then starts at address 0.
- R11: In reset and right after it, the op is NOP, `in_re` is low and `mb_done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| in_data | input | 32 | head word of the input FIFO |
| in_empty | input | 1 | input FIFO has no word |
| in_re | output | 1 | pop the head word |
| obj_op | output | 2 | object FIFO op: 0 NOP, 1 WRITE, 2 COMMIT |
| obj_addr | output | 9 | word slot inside the object |
| obj_data | output | 32 | word to write |
| obj_full | input | 1 | object FIFO cannot accept an op |
| mb_done | output | 1 | one-cycle pulse after each commit |
| mb_words | output | 9 | words written for the last committed macroblock |

## Verification
The in-RTL assertions check these properties on every cycle:
- pops never happen against an empty input, and a full object FIFO freezes all traffic;
- consecutive writes climb in address;
- a commit never pops a word;
- every done pulse follows a commit and reports a count within the object's size.

Which groups are present for a given set of header flags, the exact slot of every word, and the exact word count can only be shown by the bench scenarios. These cover intra 4x4, intra 16x16 with and without luma AC, inter with an 8x8 transform, and inter with the type-zero flag set, in both P and B slices, under back-to-back, gapped and back-pressured traffic.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

    localparam int NGRP = 10;

    typedef enum logic [3:0] {
        G_HDR   = 4'd0,
        G_IMODE = 4'd1,
        G_REF   = 4'd2,
        G_MVD   = 4'd3,
        G_L4    = 4'd4,
        G_L8    = 4'd5,
        G_LDC   = 4'd6,
        G_L16AC = 4'd7,
        G_CDC   = 4'd8,
        G_CAC   = 4'd9
    } grp_e;

    typedef enum logic [1:0] {
        OP_NOP    = 2'd0,
        OP_WRITE  = 2'd1,
        OP_COMMIT = 2'd2
    } obj_op_e;

    typedef struct packed {
        logic       inter;
        logic       i16;
        logic       type0;
        logic       bslice;
        logic       t8;
        logic [5:0] cbp;
    } mb_flags_t;

endpackage

// File: rtl/mbp_group_plan.sv
module mbp_group_plan
    import mbp_pkg::*;
(
    input  mb_flags_t         flags,
    output logic [NGRP-1:0]   present
);
    logic res;
    logic cbp_nz;
    logic luma_nz;

    always_comb begin
        cbp_nz  = (flags.cbp != 6'd0);
        luma_nz = (flags.cbp[3:0] != 4'd0);
        // R4: residual gating
        res     = !flags.type0 || (flags.bslice && cbp_nz);

        present          = '0;
        present[G_HDR]   = 1'b1;
        present[G_IMODE] = !flags.inter;
        present[G_REF]   = flags.inter;
        present[G_MVD]   = flags.inter;
        present[G_L4]    = res && !flags.i16 && cbp_nz && !flags.t8;
        present[G_L8]    = res && !flags.i16 && cbp_nz && flags.t8;
        present[G_LDC]   = res && flags.i16;
        present[G_L16AC] = res && flags.i16 && luma_nz;
        present[G_CDC]   = res && (flags.cbp > 6'd15);
        present[G_CAC]   = res && (flags.cbp[5:4] == 2'd2);
    end
endmodule

// File: rtl/mbp_group_map.sv
module mbp_group_map
    import mbp_pkg::*;
#(
    parameter int HDR_LEN   = 5,
    parameter int IMODE_LEN = 8,
    parameter int REF_LEN   = 9,
    parameter int MVD_LEN   = 32,
    parameter int LUMA_LEN  = 128,
    parameter int LDC_LEN   = 16,
    parameter int L16AC_LEN = 112,
    parameter int CDC_LEN   = 8,
    parameter int CAC_LEN   = 58,
    parameter int ADDR_W    = 9,
    parameter int CNT_W     = 9
) (
    input  grp_e              grp,
    input  logic [CNT_W-1:0]  widx,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam int B_IMODE = HDR_LEN;
    localparam int B_REF   = B_IMODE + IMODE_LEN;
    localparam int B_MVD   = B_REF + REF_LEN;
    localparam int B_L4    = B_MVD + MVD_LEN;
    localparam int B_L8    = B_L4 + LUMA_LEN;
    localparam int B_LDC   = B_L8 + LUMA_LEN;
    localparam int B_L16AC = B_LDC + LDC_LEN;
    localparam int B_CDC   = B_L16AC + L16AC_LEN;
    localparam int B_CAC   = B_CDC + CDC_LEN;

    int base;
    int len;

    always_comb begin
        case (grp)
            G_HDR:   begin base = 0;       len = HDR_LEN;   end
            G_IMODE: begin base = B_IMODE; len = IMODE_LEN; end
            G_REF:   begin base = B_REF;   len = REF_LEN;   end
            G_MVD:   begin base = B_MVD;   len = MVD_LEN;   end
            G_L4:    begin base = B_L4;    len = LUMA_LEN;  end
            G_L8:    begin base = B_L8;    len = LUMA_LEN;  end
            G_LDC:   begin base = B_LDC;   len = LDC_LEN;   end
            G_L16AC: begin base = B_L16AC; len = L16AC_LEN; end
            G_CDC:   begin base = B_CDC;   len = CDC_LEN;   end
            G_CAC:   begin base = B_CAC;   len = CAC_LEN;   end
            default: begin base = 0;       len = 1;         end
        endcase
        addr = ADDR_W'(base + int'(widx));
        last = (int'(widx) == len - 1);
    end
endmodule

// File: rtl/mb_obj_packer.sv
module mb_obj_packer
    import mbp_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int HDR_LEN   = 5,
    parameter int IMODE_LEN = 8,
    parameter int REF_LEN   = 9,
    parameter int MVD_LEN   = 32,
    parameter int LUMA_LEN  = 128,
    parameter int LDC_LEN   = 16,
    parameter int L16AC_LEN = 112,
    parameter int CDC_LEN   = 8,
    parameter int CAC_LEN   = 58,
    parameter int INTER_BIT = 0,
    parameter int I16_BIT   = 1,
    parameter int TYPE0_BIT = 2,
    parameter int BSL_BIT   = 3,
    parameter int T8_BIT    = 4,
    parameter int CBP_LSB   = 8,
    localparam int OBJ_WORDS = HDR_LEN + IMODE_LEN + REF_LEN + MVD_LEN + 2 * LUMA_LEN
                             + LDC_LEN + L16AC_LEN + CDC_LEN + CAC_LEN,
    localparam int ADDR_W    = $clog2(OBJ_WORDS),
    localparam int CNT_W     = $clog2(OBJ_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_empty,
    output logic              in_re,
    output logic [1:0]        obj_op,
    output logic [ADDR_W-1:0] obj_addr,
    output logic [DATA_W-1:0] obj_data,
    input  logic              obj_full,
    output logic              mb_done,
    output logic [CNT_W-1:0]  mb_words
);
    typedef struct packed {
        logic             commit;
        grp_e             grp;
        logic [CNT_W-1:0] widx;
        mb_flags_t        flags;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic [CNT_W-1:0] words;
    } st_t;

    st_t st_d, st_q;

    mb_flags_t       hdr_flags;
    mb_flags_t       eff_flags;
    logic [NGRP-1:0] present;
    logic [ADDR_W-1:0] map_addr;
    logic            map_last;
    grp_e            nxt_grp;
    logic            nxt_found;
    logic            first_word;

    always_comb begin
        hdr_flags.inter  = in_data[INTER_BIT];
        hdr_flags.i16    = in_data[I16_BIT];
        hdr_flags.type0  = in_data[TYPE0_BIT];
        hdr_flags.bslice = in_data[BSL_BIT];
        hdr_flags.t8     = in_data[T8_BIT];
        hdr_flags.cbp    = in_data[CBP_LSB +: 6];
        first_word       = (st_q.grp == G_HDR) && (st_q.widx == '0);
        eff_flags        = first_word ? hdr_flags : st_q.flags;
    end

    mbp_group_plan u_plan (
        .flags   (eff_flags),
        .present (present)
    );

    mbp_group_map #(
        .HDR_LEN(HDR_LEN), .IMODE_LEN(IMODE_LEN), .REF_LEN(REF_LEN),
        .MVD_LEN(MVD_LEN), .LUMA_LEN(LUMA_LEN), .LDC_LEN(LDC_LEN),
        .L16AC_LEN(L16AC_LEN), .CDC_LEN(CDC_LEN), .CAC_LEN(CAC_LEN),
        .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) u_map (
        .grp  (st_q.grp),
        .widx (st_q.widx),
        .addr (map_addr),
        .last (map_last)
    );

    // first present group after the current one
    always_comb begin
        nxt_grp   = G_HDR;
        nxt_found = 1'b0;
        for (int i = 0; i < NGRP; i++) begin
            if (!nxt_found && i > int'(st_q.grp) && present[i]) begin
                nxt_grp   = grp_e'(i);
                nxt_found = 1'b1;
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        in_re     = 1'b0;
        obj_op    = OP_NOP;
        obj_addr  = '0;
        obj_data  = '0;
        if (st_q.commit) begin
            if (!obj_full) begin
                obj_op     = OP_COMMIT;
                st_d.commit = 1'b0;
                st_d.grp   = G_HDR;
                st_d.widx  = '0;
                st_d.cnt   = '0;
                st_d.done  = 1'b1;
                st_d.words = st_q.cnt;
            end
        end else if (!in_empty && !obj_full) begin
            in_re     = 1'b1;
            obj_op    = OP_WRITE;
            obj_addr  = map_addr;
            obj_data  = in_data;
            st_d.cnt  = st_q.cnt + 1'b1;
            if (first_word)
                st_d.flags = hdr_flags;
            if (map_last) begin
                st_d.widx = '0;
                if (nxt_found) st_d.grp    = nxt_grp;
                else           st_d.commit = 1'b1;
            end else begin
                st_d.widx = st_q.widx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{commit: 1'b0, grp: G_HDR, widx: '0, flags: '0,
                      cnt: '0, done: 1'b0, words: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mb_done  = st_q.done;
    assign mb_words = st_q.words;

    // R5: never pop an empty input
    a_r5_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        in_re |-> !in_empty);

    // R6: back-pressure freezes all traffic
    a_r6_full_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        obj_full |-> (obj_op == OP_NOP && !in_re));

    // R2: consecutive writes climb in address
    a_r2_addr_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (obj_op == OP_WRITE && $past(obj_op) == OP_WRITE) |-> obj_addr > $past(obj_addr));

    // R10: commit consumes no input word
    a_r10_commit_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (obj_op == OP_COMMIT) |-> !in_re);

    // R10: done pulse follows a commit
    a_r10_done_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        mb_done |-> $past(obj_op == OP_COMMIT));

    // R10: reported count fits the object
    a_r10_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        mb_done |-> (int'(mb_words) >= HDR_LEN && int'(mb_words) <= OBJ_WORDS));

endmodule

// File: tb/test_mb_obj_packer.sv
module test_mb_obj_packer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_empty = 1'b1;
    logic        in_re;
    logic [1:0]  obj_op;
    logic [8:0]  obj_addr;
    logic [31:0] obj_data;
    logic        obj_full = 1'b0;
    logic        mb_done;
    logic [8:0]  mb_words;

    always #10 clk = ~clk;   // 50 MHz

    mb_obj_packer i_mb_obj_packer (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_empty(in_empty),
        .in_re(in_re), .obj_op(obj_op), .obj_addr(obj_addr), .obj_data(obj_data),
        .obj_full(obj_full), .mb_done(mb_done), .mb_words(mb_words)
    );

    int tests = 0;
    int fails = 0;

    logic [31:0] in_q[$];
    int          ex_op[$];
    int          ex_addr[$];
    logic [31:0] ex_data[$];
    string       ex_req[$];
    int          ex_cnt[$];

    bit run = 0;
    bit gap_en = 0;
    bit full_en = 0;
    int cyc = 0;
    bit pend_done = 0;
    int pend_cnt = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic emit(int base, int len, int id, ref int n, input logic [31:0] w0, input string req);
        for (int k = 0; k < len; k++) begin
            logic [31:0] w;
            w = (n == 0) ? w0 : (32'hA500_0000 | (32'(id) << 16) | 32'(n));
            in_q.push_back(w);
            ex_op.push_back(1);
            ex_addr.push_back(base + k);
            ex_data.push_back(w);
            ex_req.push_back(req);
            n++;
        end
    endtask

    // independent group layout from the requirements
    task automatic build_mb(int id, bit inter, bit i16, bit t0, bit bs, bit t8, logic [5:0] cbp);
        logic [31:0] w0;
        bit res;
        int n;
        n  = 0;
        w0 = (32'(cbp) << 8) | (32'(t8) << 4) | (32'(bs) << 3) | (32'(t0) << 2)
           | (32'(i16) << 1) | 32'(inter);
        res = !t0 || (bs && cbp != 0);
        emit(0, 5, id, n, w0, "R1");
        if (!inter) emit(5, 8, id, n, w0, "R1");
        else begin
            emit(13, 9, id, n, w0, "R3");
            emit(22, 32, id, n, w0, "R3");
        end
        if (res) begin
            if (!i16 && cbp != 0) emit(t8 ? 182 : 54, 128, id, n, w0, "R7");
            if (i16) begin
                emit(310, 16, id, n, w0, "R8");
                if (cbp[3:0] != 0) emit(326, 112, id, n, w0, "R8");
            end
            if (cbp > 15) emit(438, 8, id, n, w0, "R9");
            if (cbp[5:4] == 2) emit(446, 58, id, n, w0, "R9");
        end
        ex_op.push_back(2);
        ex_addr.push_back(-1);
        ex_data.push_back('0);
        ex_req.push_back(res ? "R10" : "R4 R10");
        ex_cnt.push_back(n);
    endtask

    always @(negedge clk) begin
        if (run) begin
            cyc++;
            in_empty = (in_q.size() == 0) || (gap_en && (cyc % 7 == 3));
            in_data  = (in_q.size() != 0) ? in_q[0] : 32'h0;
            obj_full = full_en && ((cyc % 5 == 1) || (cyc % 5 == 2));
            #1;
            if (pend_done) begin
                chk(mb_done == 1'b1, "R10", "done pulse", int'(mb_done), 1);
                chk(int'(mb_words) == pend_cnt, "R10", "word count", int'(mb_words), pend_cnt);
                pend_done = 0;
            end else begin
                chk(mb_done == 1'b0, "R10", "spurious done", int'(mb_done), 0);
            end
            if (obj_full)
                chk(obj_op == 2'd0 && !in_re, "R6", "activity while full", int'(obj_op), 0);
            if (in_empty)
                chk(!in_re, "R5", "pop while empty", int'(in_re), 0);
            if (in_re)
                chk(obj_op == 2'd1, "R2", "pop without write", int'(obj_op), 1);
            if (obj_op != 2'd0) begin
                if (ex_op.size() == 0) begin
                    chk(1'b0, "R10", "unexpected op", int'(obj_op), 0);
                end else begin
                    string r;
                    r = ex_req[0];
                    chk(int'(obj_op) == ex_op[0], r, "op", int'(obj_op), ex_op[0]);
                    if (ex_op[0] == 1) begin
                        chk(int'(obj_addr) == ex_addr[0], r, "addr", int'(obj_addr), ex_addr[0]);
                        chk(obj_data == ex_data[0], "R2", "data", int'(obj_data), int'(ex_data[0]));
                    end else if (obj_op == 2'd2) begin
                        pend_done = 1;
                        pend_cnt  = ex_cnt.pop_front();
                    end
                    void'(ex_op.pop_front());
                    void'(ex_addr.pop_front());
                    void'(ex_data.pop_front());
                    void'(ex_req.pop_front());
                end
            end
            if (in_re && in_q.size() != 0) void'(in_q.pop_front());
        end
    end

    task automatic drain(ref bit hung);
        int wd;
        wd = 0;
        while ((ex_op.size() != 0 || pend_done) && wd < 20000) begin
            @(negedge clk);
            wd++;
        end
        if (wd >= 20000) hung = 1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        bit hung;
        hung = 0;
        repeat (3) @(negedge clk);
        #1;
        // R11: reset state
        chk(obj_op == 2'd0, "R11", "op in reset", int'(obj_op), 0);
        chk(!in_re, "R11", "in_re in reset", int'(in_re), 0);
        chk(!mb_done, "R11", "done in reset", int'(mb_done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(obj_op == 2'd0 && !in_re && !mb_done, "R11", "idle after reset", int'(obj_op), 0);
        run = 1;

        // back-to-back traffic
        build_mb(1, 0, 0, 0, 0, 0, 6'h2F);  // intra 4x4, full chroma
        build_mb(2, 0, 1, 0, 0, 0, 6'h1F);  // intra 16x16 with luma AC, chroma DC
        build_mb(3, 0, 1, 0, 0, 0, 6'h00);  // intra 16x16, DC only
        build_mb(4, 1, 0, 0, 0, 1, 6'h05);  // inter, 8x8 transform
        drain(hung);

        // gaps on input and back-pressure on output
        gap_en  = 1;
        full_en = 1;
        build_mb(5, 1, 0, 1, 0, 0, 6'h3F);  // R4: type zero, P slice -> no residual
        build_mb(6, 1, 0, 1, 1, 0, 6'h21);  // R4: type zero, B slice, cbp nonzero
        build_mb(7, 1, 0, 1, 1, 0, 6'h00);  // R4: type zero, B slice, cbp zero
        build_mb(8, 0, 1, 0, 0, 0, 6'h2A);  // intra 16x16 with chroma AC
        build_mb(9, 0, 0, 0, 0, 1, 6'h11);  // intra 8x8 transform
        drain(hung);

        chk(!hung, "R10", "watchdog", int'(hung), 0);
        chk(ex_op.size() == 0, "R10", "leftover expected ops", ex_op.size(), 0);
        chk(in_q.size() == 0, "R5", "leftover input words", in_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule